// File: doc/BRIEF.md
# Key-Guarded Register File

This block is a small memory-mapped register file with a write guard in front of it. Two kick registers sit in the address map and are always writable. Writes to the guarded words are dropped unless each kick register holds its own 32-bit magic word at the same time. Storing any other value in either kick register locks the file again. Reads are never gated, so software can inspect every register, including the scratch words, whatever the lock state.

The guarded words are a parameterised bank of control registers at the bottom of the map and three 32-bit scratch words that keep arbitrary software data. Access uses a single-cycle port. A write is taken on the clock edge where the write enable is high. Read data is a combinational function of the address and the stored state.

To unlock, software writes both magic words and then writes the guarded registers. To lock again, it clears the kick registers.

Top module: `keyed_regfile`

## Requirements
- R1: After reset both kick registers, every control register and every scratch word read as zero, and `unlocked` is low.
- R2: The kick registers at 0x6C (first key) and 0x70 (second key) accept a write whatever the lock state, and a read at the same address returns the last value written.
- R3: `unlocked` is high exactly when the first kick register holds 0x83E70B13 and the second holds 0x95A4F1E0. It follows a kick write on the clock edge that stores it and changes at no other time.
- R4: While unlocked, a write to control register n at byte offset 4*n (n below NUM_CTRL) stores the write data, which then reads back at that offset.
- R5: While unlocked, writes to the scratch words at 0x60, 0x64 and 0x68 are stored and read back unchanged.
- R6: While locked, a write to a control register or a scratch word is dropped and the register keeps its previous value.
- R7: Writing any value other than its magic word into either kick register locks the file, and later guarded writes are dropped.
- R8: Reads are never blocked: every register reads its stored value whether the file is locked or unlocked.
- R9: A write to an address that is unmapped or not a multiple of four changes no register, and a read from such an address returns zero.
- R10: The order in which the two kick registers are loaded does not matter. The file unlocks as soon as the second of the two magic words is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, taken on the rising clock edge |
| addr | input | ADDR_W | Byte address for both read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| unlocked | output | 1 | High while both keys hold their magic words |

## Verification
A corrupted kick register or a wrong lock flag shows up in one of two ways. Either `unlocked` changes without a write to a kick address, or it disagrees with the kick values that read back. Both are visible on the cycle after the faulty write. A write that slips through while the file is locked, or a dropped write while it is unlocked, shows up in the read data of the target address as soon as that address is presented. The sweeps therefore read back the whole map after every phase. A decoder that aliases an address reveals itself when a write to one address changes the data read at a different one.

// File: rtl/keyed_regfile_pkg.sv
package keyed_regfile_pkg;
  // Index width shared by every register bank (up to 16 words per bank).
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_SCR,
    SEL_KEY0,
    SEL_KEY1
  } selKind_e;

  // Decoded target of the current address.
  typedef struct packed {
    selKind_e         kind;
    logic [IDX_W-1:0] idx;
  } regSel_t;

  // Strobes from control to datapath; already gated by the lock state.
  typedef struct packed {
    logic             ctrlWr;
    logic             scrWr;
    logic [IDX_W-1:0] idx;
  } wrStrobe_t;
endpackage

// File: rtl/keyed_regfile_ctrl.sv
module keyed_regfile_ctrl
  import keyed_regfile_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter int              DATA_W       = 32,
  parameter int              NUM_CTRL     = 4,
  parameter int              NUM_SCRATCH  = 3,
  parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] KEY0_OFF   = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFF   = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL   = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_VAL   = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output regSel_t           rdSel,
  output wrStrobe_t         wrStb,
  output logic [DATA_W-1:0] kick0Q,
  output logic [DATA_W-1:0] kick1Q,
  output logic              unlocked
);
  localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(NUM_CTRL * 4);
  localparam logic [ADDR_W-1:0] SCR_SPAN   = ADDR_W'(NUM_SCRATCH * 4);

  logic [ADDR_W-1:0] scrOff;
  regSel_t           dec;

  // Address decode: the same decode serves the read mux and the write strobes.
  always_comb begin
    scrOff    = addr - SCRATCH_BASE;
    dec.kind  = SEL_NONE;
    dec.idx   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < CTRL_LIMIT) begin
        dec.kind = SEL_CTRL;
        dec.idx  = addr[IDX_W+1:2];
      end else if (addr == KEY0_OFF) begin
        dec.kind = SEL_KEY0;
      end else if (addr == KEY1_OFF) begin
        dec.kind = SEL_KEY1;
      end else if (addr >= SCRATCH_BASE && scrOff < SCR_SPAN) begin
        dec.kind = SEL_SCR;
        dec.idx  = scrOff[IDX_W+1:2];
      end
    end
  end

  // Kick registers are never guarded.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kick0Q <= '0;
      kick1Q <= '0;
    end else if (wrEn) begin
      if (dec.kind == SEL_KEY0) kick0Q <= wrData;
      if (dec.kind == SEL_KEY1) kick1Q <= wrData;
    end
  end

  assign unlocked = (kick0Q == KEY0_VAL) && (kick1Q == KEY1_VAL);

  always_comb begin
    rdSel        = dec;
    wrStb.idx    = dec.idx;
    wrStb.ctrlWr = wrEn && unlocked && (dec.kind == SEL_CTRL);
    wrStb.scrWr  = wrEn && unlocked && (dec.kind == SEL_SCR);
  end
endmodule

// File: rtl/keyed_regfile_dp.sv
module keyed_regfile_dp
  import keyed_regfile_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_CTRL    = 4,
  parameter int NUM_SCRATCH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] kick0Q,
  input  logic [DATA_W-1:0] kick1Q,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] ctrlQ [NUM_CTRL];
  logic [DATA_W-1:0] scrQ  [NUM_SCRATCH];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlQ[i] <= '0;
      else if (wrStb.ctrlWr && wrStb.idx == IDX_W'(i))
        ctrlQ[i] <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        scrQ[i] <= '0;
      else if (wrStb.scrWr && wrStb.idx == IDX_W'(i))
        scrQ[i] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel.kind)
      SEL_CTRL:
        for (int i = 0; i < NUM_CTRL; i++)
          if (rdSel.idx == IDX_W'(i)) rdData = ctrlQ[i];
      SEL_SCR:
        for (int i = 0; i < NUM_SCRATCH; i++)
          if (rdSel.idx == IDX_W'(i)) rdData = scrQ[i];
      SEL_KEY0: rdData = kick0Q;
      SEL_KEY1: rdData = kick1Q;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/keyed_regfile.sv
module keyed_regfile
  import keyed_regfile_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter int              DATA_W       = 32,
  parameter int              NUM_CTRL     = 4,
  parameter int              NUM_SCRATCH  = 3,
  parameter logic [ADDR_W-1:0] SCRATCH_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] KEY0_OFF   = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFF   = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL   = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_VAL   = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              unlocked
);
  regSel_t           rdSel;
  wrStrobe_t         wrStb;
  logic [DATA_W-1:0] kick0Q;
  logic [DATA_W-1:0] kick1Q;

  keyed_regfile_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL),
    .NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE),
    .KEY0_OFF(KEY0_OFF), .KEY1_OFF(KEY1_OFF),
    .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdSel(rdSel), .wrStb(wrStb), .kick0Q(kick0Q), .kick1Q(kick1Q),
    .unlocked(unlocked)
  );

  keyed_regfile_dp #(
    .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .NUM_SCRATCH(NUM_SCRATCH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .rdSel(rdSel), .kick0Q(kick0Q), .kick1Q(kick1Q), .rdData(rdData)
  );
endmodule

// File: rtl/keyed_regfile_chk.sv
module keyed_regfile_chk #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] KEY0_OFF = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFF = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_VAL = 32'h95A4_F1E0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              unlocked
);
  // R3: the lock state moves only on a kick write.
  p_lock_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || (addr != KEY0_OFF && addr != KEY1_OFF)) |=> $stable(unlocked));

  // R3: storing the second key again while unlocked keeps the file unlocked.
  p_keep_unlock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && wrEn && addr == KEY1_OFF && wrData == KEY1_VAL) |=> unlocked);

  // R7: a wrong value in either key locks the file.
  p_relock_k0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == KEY0_OFF && wrData != KEY0_VAL) |=> !unlocked);
  p_relock_k1_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == KEY1_OFF && wrData != KEY1_VAL) |=> !unlocked);

  // R2: a kick register reads back what was written.
  p_kick_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == KEY0_OFF) |=> (addr != KEY0_OFF) || (rdData == $past(wrData)));

  // R6: a locked write leaves the read data of its address unchanged.
  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && wrEn && addr != KEY0_OFF && addr != KEY1_OFF)
      |=> (addr != $past(addr)) || (rdData == $past(rdData)));

  // R8: with no write, the data read at a fixed address stays put.
  p_read_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (addr != $past(addr)) || (rdData == $past(rdData)));

  // R9: misaligned addresses read zero.
  always_comb begin
    if (rstN && addr[1:0] != 2'b00)
      p_misaligned_zero_r9: assert (rdData == '0);
  end
endmodule

bind keyed_regfile keyed_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY0_OFF(KEY0_OFF), .KEY1_OFF(KEY1_OFF),
  .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .unlocked(unlocked)
);

// File: tb/keyed_regfile_tb_top.sv
module keyed_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        unlocked;

  int nChecks = 0;
  int nFail = 0;

  logic [31:0] mCtrl [4];
  logic [31:0] mScr  [3];
  logic [31:0] mK0, mK1;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_regfile dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .unlocked(unlocked)
  );

  function automatic logic mUnlocked();
    return (mK0 == K0) && (mK1 == K1);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 8'h10) return mCtrl[a[3:2]];
    if (a == 8'h60) return mScr[0];
    if (a == 8'h64) return mScr[1];
    if (a == 8'h68) return mScr[2];
    if (a == 8'h6C) return mK0;
    if (a == 8'h70) return mK1;
    return 32'h0;
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (a == 8'h6C || a == 8'h70) return "R2";
    if (a[1:0] == 2'b00 && (a < 8'h10 || a == 8'h60 || a == 8'h64 || a == 8'h68)) begin
      if (!mUnlocked()) return "R6";
      return (a < 8'h10) ? "R4" : "R5";
    end
    return "R9";
  endfunction

  function automatic logic [31:0] pat(input logic [7:0] a, input logic [7:0] seed);
    return {seed, a, ~a, a ^ 8'h5A};
  endfunction

  // Reference model update, derived from the requirements.
  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    logic u;
    u = mUnlocked();
    if (a == 8'h6C) mK0 = d;
    else if (a == 8'h70) mK1 = d;
    else if (u && a[1:0] == 2'b00) begin
      if (a < 8'h10) mCtrl[a[3:2]] = d;
      else if (a == 8'h60) mScr[0] = d;
      else if (a == 8'h64) mScr[1] = d;
      else if (a == 8'h68) mScr[2] = d;
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic chkRead(input logic [7:0] a, input string tag);
    logic [31:0] e;
    wrEn = 1'b0; addr = a;
    #1;
    e = expRead(a);
    nChecks++;
    if (rdData !== e) begin
      nFail++;
      $display("FAIL %s read addr=%02h actual=%08h expected=%08h", tag, a, rdData, e);
    end
  endtask

  task automatic chkLock(input logic e, input string tag);
    #1;
    nChecks++;
    if (unlocked !== e) begin
      nFail++;
      $display("FAIL %s unlocked actual=%0b expected=%0b", tag, unlocked, e);
    end
  endtask

  task automatic readAll(input string tag);
    for (int w = 0; w < 64; w++) chkRead(8'(w * 4), tag);
  endtask

  task automatic writeSweep(input logic [7:0] seed);
    for (int w = 0; w < 64; w++) begin
      logic [7:0] a;
      a = 8'(w * 4);
      if (a != 8'h6C && a != 8'h70) begin
        string t;
        t = tagOf(a);
        busWrite(a, pat(a, seed));
        chkRead(a, t);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail + 1, nChecks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mCtrl[i] = '0;
    for (int i = 0; i < 3; i++) mScr[i] = '0;
    mK0 = '0; mK1 = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkLock(1'b0, "R1");
    readAll("R1");

    // R6, R8, R9: locked sweep drops guarded writes; reads still work
    writeSweep(8'h11);
    readAll("R8");

    // R3, R2: unlock in normal order
    busWrite(8'h6C, K0);
    chkLock(1'b0, "R3");
    chkRead(8'h6C, "R2");
    busWrite(8'h70, K1);
    chkLock(1'b1, "R3");
    chkRead(8'h70, "R2");

    // R4, R5: unlocked sweep stores guarded writes
    writeSweep(8'h22);
    readAll("R8");
    chkLock(1'b1, "R3");

    // R9: misaligned writes change nothing and read zero
    for (int a = 0; a < 256; a++) begin
      if (a[1:0] != 2'b00) busWrite(8'(a), 32'hDEAD_BEEF);
    end
    chkLock(1'b1, "R9");
    for (int a = 0; a < 256; a++) chkRead(8'(a), "R9");

    // R7: wrong second key locks the file
    busWrite(8'h70, 32'h0);
    chkLock(1'b0, "R7");
    writeSweep(8'h33);
    readAll("R7");

    // R10: reverse order unlocks
    busWrite(8'h6C, 32'h0);
    busWrite(8'h70, K1);
    chkLock(1'b0, "R10");
    busWrite(8'h6C, K0);
    chkLock(1'b1, "R10");
    busWrite(8'h64, 32'hCAFE_0064);
    chkRead(8'h64, "R10");

    // R7: near-miss first key locks the file
    busWrite(8'h6C, K0 ^ 32'h1);
    chkLock(1'b0, "R7");
    busWrite(8'h64, 32'h0BAD_0BAD);
    chkRead(8'h64, "R7");
    busWrite(8'h04, 32'h0BAD_0BAD);
    chkRead(8'h04, "R7");
    readAll("R8");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule